// File: doc/BRIEF.md
# Critical-Word-First Line Fill Controller

This block handles read requests from a CPU into a small two-way set-associative cache and manages the refills that misses cause. Each request is a word address. The block compares its tag against both ways of the indexed set, and a way counts only if its valid bit is set. A hit returns the stored word combinationally in the same cycle. A miss invalidates the victim way and sends one line request to the next memory level. The four beats that come back are written into the cache in the background.

The CPU restarts early. It holds `cpu_req` and `cpu_addr` until `cpu_rdy` is high, and the missed word is handed back in the very cycle its beat appears on `mem_valid`. It does not wait for the line to complete. With `cfg_wrap` high, memory is asked to start at the missed word and wrap around the line. With `cfg_wrap` low, the fill starts at word 0 and the CPU waits only until its own word has arrived.

While a fill is in flight, a request to another word of the same line is served from the fill buffer or from the arriving beat. A request to any other line waits until the refill finishes, because the refill has priority.

The controller is a three-state machine:
- `ST_IDLE` performs lookups. It moves to `ST_ISSUE` when a request misses.
- `ST_ISSUE` raises `mem_req` for one cycle and always moves on to `ST_FILL`.
- `ST_FILL` takes in beats. It returns to `ST_IDLE` in the cycle the last beat is accepted, and in that same cycle the line's tag and valid bit are committed.

Top module: `line_fill_ctrl`

## Requirements
- R1: `cpu_addr` is a word address: bits [1:0] select the word in a four-word line, bits [3:2] select one of four sets, and the upper six bits are the tag. In `ST_IDLE`, a request whose tag equals that of a valid way in the indexed set gets `cpu_rdy` high in the same cycle, with that word on `cpu_rdata`.
- R2: A request that matches no valid way gets no `cpu_rdy` in that cycle. In the next cycle `mem_req` is high for exactly one cycle, with `mem_line` equal to `cpu_addr[9:2]`.
- R3: With `cfg_wrap`=1, `mem_first` equals the missed word offset, and memory returns offsets first, first+1, ... modulo 4. With `cfg_wrap`=0, `mem_first` is 0.
- R4: The missed word is returned with `cpu_rdy` in the cycle its beat is on `mem_valid`/`mem_data`. This happens before the remaining beats of the line.
- R5: During a fill, a request to the same line is served without a new memory request. If its word has already arrived, it is served at once. Otherwise it is served exactly in the cycle of that word's beat.
- R6: During a fill, a request to a different line keeps `cpu_rdy` low until the fill has completed, even when that line is resident.
- R7: A filled line becomes valid only after its fourth beat. From then on, every word of the line hits with no new `mem_req`.
- R8: Each set has a round-robin bit that picks the victim way and toggles on every fill. When a third distinct line fills a set, it evicts the older of the two resident lines, and the newer one still hits.
- R9: After reset all lines are invalid, and `mem_req` and `cpu_rdy` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wrap | input | 1 | 1: critical word first with wrap; 0: fill from word 0 |
| cpu_req | input | 1 | CPU read request, held until `cpu_rdy` |
| cpu_addr | input | 10 | Requested word address |
| cpu_rdy | output | 1 | Read data valid for the current request |
| cpu_rdata | output | 32 | Read data |
| mem_req | output | 1 | One-cycle line request to memory |
| mem_line | output | 8 | Line address (tag and set) of the refill |
| mem_first | output | 2 | Word offset memory must return first |
| mem_valid | input | 1 | A refill beat is present |
| mem_data | input | 32 | Refill beat data |

## Verification
The bench sweeps every missed word offset in every set, once in wrapping order and once in sequential order. Memory latency and the gaps between beats vary throughout, so the two orders differ both in which beat releases the CPU and in which follow-up words stall. After each miss, the remaining words of the line are requested while the fill is still running. This separates a buffer hit from a stall-until-beat, and shows when the line becomes a true cache hit. Two directed sequences complete the picture. One fills three lines into a single set, which exposes the round-robin victim. The other requests a resident line during another line's fill, which exposes the refill-first priority.

// File: rtl/lfc_pkg.sv
`timescale 1ns/1ps
package lfc_pkg;

    localparam int WAYS = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_FILL  = 2'd2
    } lfc_state_e;

endpackage

// File: rtl/lfc_tag_store.sv
`timescale 1ns/1ps
module lfc_tag_store #(
    parameter int SETS  = 4,
    parameter int TAG_W = 6,
    parameter int IDX_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] lk_idx,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             hit,
    output logic             hit_way,
    output logic             victim_way,
    input  logic             inval_en,
    input  logic [IDX_W-1:0] inval_idx,
    input  logic             inval_way,
    input  logic             fill_en,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic             fill_way,
    input  logic [TAG_W-1:0] fill_tag
);
    import lfc_pkg::*;

    logic [WAYS-1:0] way_hit;
    logic [SETS-1:0] rr_q;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic [TAG_W-1:0] tag_q   [SETS];
        logic [SETS-1:0]  valid_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                valid_q <= '0;
                for (int s = 0; s < SETS; s++) tag_q[s] <= '0;
            end else begin
                if (inval_en && inval_way == 1'(w)) valid_q[inval_idx] <= 1'b0;
                if (fill_en && fill_way == 1'(w)) begin
                    valid_q[fill_idx] <= 1'b1;
                    tag_q[fill_idx]   <= fill_tag;
                end
            end
        end

        assign way_hit[w] = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rr_q <= '0;
        else if (fill_en) rr_q[fill_idx] <= ~rr_q[fill_idx];
    end

    assign hit        = |way_hit;
    assign hit_way    = way_hit[1];
    assign victim_way = rr_q[lk_idx];

    AST_SINGLE_WAY_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(way_hit)); // R1

endmodule

// File: rtl/lfc_data_store.sv
`timescale 1ns/1ps
module lfc_data_store #(
    parameter int SETS   = 4,
    parameter int WORDS  = 4,
    parameter int DATA_W = 32,
    parameter int IDX_W  = $clog2(SETS),
    parameter int OFF_W  = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic              rd_way,
    input  logic [OFF_W-1:0]  rd_off,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_way,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic [DATA_W-1:0] wr_data
);
    localparam int A_W   = 1 + IDX_W + OFF_W;
    localparam int DEPTH = 1 << A_W;

    logic [DATA_W-1:0] store_q [DEPTH];
    logic [A_W-1:0]    rd_a;
    logic [A_W-1:0]    wr_a;

    assign rd_a = {rd_way, rd_idx, rd_off};
    assign wr_a = {wr_way, wr_idx, wr_off};

    always_ff @(posedge clk) begin
        if (wr_en) store_q[wr_a] <= wr_data;
    end

    assign rd_data = store_q[rd_a];

endmodule

// File: rtl/lfc_fill_buf.sv
`timescale 1ns/1ps
module lfc_fill_buf #(
    parameter int WORDS  = 4,
    parameter int DATA_W = 32,
    parameter int OFF_W  = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [OFF_W-1:0]  start_first,
    input  logic              beat,
    input  logic [DATA_W-1:0] beat_data,
    input  logic [OFF_W-1:0]  rd_off,
    output logic [OFF_W-1:0]  first,
    output logic [OFF_W-1:0]  beat_off,
    output logic              last_beat,
    output logic              rd_ready,
    output logic [DATA_W-1:0] rd_data
);
    logic [OFF_W-1:0]  first_q;
    logic [OFF_W-1:0]  cnt_q;
    logic [WORDS-1:0]  arrived_q;
    logic [DATA_W-1:0] buf_q [WORDS];
    logic              bypass;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            first_q   <= '0;
            cnt_q     <= '0;
            arrived_q <= '0;
        end else if (start) begin
            first_q   <= start_first;
            cnt_q     <= '0;
            arrived_q <= '0;
        end else if (beat) begin
            arrived_q[beat_off] <= 1'b1;
            cnt_q               <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (beat) buf_q[beat_off] <= beat_data;
    end

    assign first     = first_q;
    assign beat_off  = first_q + cnt_q;
    assign last_beat = (cnt_q == OFF_W'(WORDS - 1));
    assign bypass    = beat && (beat_off == rd_off);
    assign rd_ready  = arrived_q[rd_off] || bypass;
    assign rd_data   = bypass ? beat_data : buf_q[rd_off];

    AST_WORD_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        beat |-> !arrived_q[beat_off]); // R5

endmodule

// File: rtl/lfc_ctrl.sv
`timescale 1ns/1ps
module lfc_ctrl (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cpu_req,
    input  logic                lk_hit,
    input  logic                same_line,
    input  logic                fb_ready,
    input  logic                mem_valid,
    input  logic                last_beat,
    output lfc_pkg::lfc_state_e state,
    output logic                start_miss,
    output logic                mem_req,
    output logic                beat,
    output logic                commit,
    output logic                cpu_rdy,
    output logic                sel_fb
);
    import lfc_pkg::*;

    lfc_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (cpu_req && !lk_hit) state_d = ST_ISSUE;
            ST_ISSUE: state_d = ST_FILL;
            ST_FILL:  if (mem_valid && last_beat) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        start_miss = 1'b0;
        mem_req    = 1'b0;
        beat       = 1'b0;
        commit     = 1'b0;
        cpu_rdy    = 1'b0;
        sel_fb     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                cpu_rdy    = cpu_req && lk_hit;
                start_miss = cpu_req && !lk_hit;
            end
            ST_ISSUE: begin
                mem_req = 1'b1;
                sel_fb  = 1'b1;
                cpu_rdy = cpu_req && same_line && fb_ready;
            end
            ST_FILL: begin
                beat    = mem_valid;
                commit  = mem_valid && last_beat;
                sel_fb  = 1'b1;
                cpu_rdy = cpu_req && same_line && fb_ready;
            end
            default: ;
        endcase
    end

    assign state = state_q;

    AST_MEM_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req); // R2

    AST_MISS_ISSUES: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && cpu_req && !lk_hit) |=> mem_req); // R2

endmodule

// File: rtl/line_fill_ctrl.sv
`timescale 1ns/1ps
module line_fill_ctrl #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 32,
    parameter int SETS   = 4,
    parameter int WORDS  = 4,
    parameter int OFF_W  = $clog2(WORDS),
    parameter int IDX_W  = $clog2(SETS),
    parameter int LINE_W = ADDR_W - OFF_W,
    parameter int TAG_W  = LINE_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wrap,
    input  logic              cpu_req,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic              cpu_rdy,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              mem_req,
    output logic [LINE_W-1:0] mem_line,
    output logic [OFF_W-1:0]  mem_first,
    input  logic              mem_valid,
    input  logic [DATA_W-1:0] mem_data
);
    import lfc_pkg::*;

    logic [OFF_W-1:0]  cpu_off;
    logic [IDX_W-1:0]  cpu_idx;
    logic [TAG_W-1:0]  cpu_tag;
    logic [LINE_W-1:0] cpu_line;

    logic [LINE_W-1:0] fill_line_q;
    logic              fill_way_q;
    logic [IDX_W-1:0]  fill_idx;
    logic [TAG_W-1:0]  fill_tag;

    logic              lk_hit, hit_way, victim_way;
    logic              same_line;
    logic              start_miss, beat, commit, sel_fb;
    lfc_state_e        state;
    logic [OFF_W-1:0]  fb_beat_off;
    logic              fb_last, fb_ready;
    logic [DATA_W-1:0] fb_data, ds_data;

    assign cpu_off  = cpu_addr[OFF_W-1:0];
    assign cpu_idx  = cpu_addr[OFF_W +: IDX_W];
    assign cpu_tag  = cpu_addr[ADDR_W-1 -: TAG_W];
    assign cpu_line = cpu_addr[ADDR_W-1:OFF_W];

    assign fill_idx  = fill_line_q[IDX_W-1:0];
    assign fill_tag  = fill_line_q[LINE_W-1:IDX_W];
    assign same_line = (cpu_line == fill_line_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fill_line_q <= '0;
            fill_way_q  <= 1'b0;
        end else if (start_miss) begin
            fill_line_q <= cpu_line;
            fill_way_q  <= victim_way;
        end
    end

    lfc_tag_store #(.SETS(SETS), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_tags (
        .clk        (clk),
        .rst_n      (rst_n),
        .lk_idx     (cpu_idx),
        .lk_tag     (cpu_tag),
        .hit        (lk_hit),
        .hit_way    (hit_way),
        .victim_way (victim_way),
        .inval_en   (start_miss),
        .inval_idx  (cpu_idx),
        .inval_way  (victim_way),
        .fill_en    (commit),
        .fill_idx   (fill_idx),
        .fill_way   (fill_way_q),
        .fill_tag   (fill_tag)
    );

    lfc_data_store #(.SETS(SETS), .WORDS(WORDS), .DATA_W(DATA_W),
                     .IDX_W(IDX_W), .OFF_W(OFF_W)) u_data (
        .clk     (clk),
        .rd_idx  (cpu_idx),
        .rd_way  (hit_way),
        .rd_off  (cpu_off),
        .rd_data (ds_data),
        .wr_en   (beat),
        .wr_idx  (fill_idx),
        .wr_way  (fill_way_q),
        .wr_off  (fb_beat_off),
        .wr_data (mem_data)
    );

    lfc_fill_buf #(.WORDS(WORDS), .DATA_W(DATA_W), .OFF_W(OFF_W)) u_fbuf (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start_miss),
        .start_first (cfg_wrap ? cpu_off : '0),
        .beat        (beat),
        .beat_data   (mem_data),
        .rd_off      (cpu_off),
        .first       (mem_first),
        .beat_off    (fb_beat_off),
        .last_beat   (fb_last),
        .rd_ready    (fb_ready),
        .rd_data     (fb_data)
    );

    lfc_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_req    (cpu_req),
        .lk_hit     (lk_hit),
        .same_line  (same_line),
        .fb_ready   (fb_ready),
        .mem_valid  (mem_valid),
        .last_beat  (fb_last),
        .state      (state),
        .start_miss (start_miss),
        .mem_req    (mem_req),
        .beat       (beat),
        .commit     (commit),
        .cpu_rdy    (cpu_rdy),
        .sel_fb     (sel_fb)
    );

    assign mem_line  = fill_line_q;
    assign cpu_rdata = sel_fb ? fb_data : ds_data;

    AST_NO_EARLY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FILL && cpu_req && same_line) |-> !lk_hit); // R7

    AST_EARLY_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FILL && mem_valid && cpu_req && same_line && fb_beat_off == cpu_off)
        |-> (cpu_rdy && cpu_rdata == mem_data)); // R4

    AST_OTHER_LINE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && cpu_req && cpu_addr[ADDR_W-1:OFF_W] != mem_line) |-> !cpu_rdy); // R6

endmodule

// File: tb/line_fill_ctrl_test.sv
`timescale 1ns/1ps
module line_fill_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wrap = 1'b1;
    logic        cpu_req = 1'b0;
    logic [9:0]  cpu_addr = '0;
    logic        cpu_rdy;
    logic [31:0] cpu_rdata;
    logic        mem_req;
    logic [7:0]  mem_line;
    logic [1:0]  mem_first;
    logic        mem_valid = 1'b0;
    logic [31:0] mem_data = '0;

    int nchk = 0;
    int nerr = 0;

    // memory model state
    int       nreq = 0;
    int       delivered = 0;
    bit       busy = 1'b0;
    logic [7:0] fl = '0;
    logic [1:0] ff = '0;
    int       lat = 1;
    int       gap = 0;

    always #2 clk = ~clk;

    line_fill_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cfg_wrap(cfg_wrap),
        .cpu_req(cpu_req), .cpu_addr(cpu_addr), .cpu_rdy(cpu_rdy), .cpu_rdata(cpu_rdata),
        .mem_req(mem_req), .mem_line(mem_line), .mem_first(mem_first),
        .mem_valid(mem_valid), .mem_data(mem_data)
    );

    function automatic logic [31:0] pat(input logic [9:0] a);
        return (32'(a) * 32'h9E3779B1) ^ 32'h3C5A0F96;
    endfunction

    function automatic logic [9:0] mk(input int t, input int s, input int o);
        return {6'(t), 2'(s), 2'(o)};
    endfunction

    task automatic chk(input bit ok, input string req, input string msg,
                       input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, msg, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    // memory: answers each request with four beats in wrap order from mem_first
    initial begin
        forever begin
            @(negedge clk);
            if (mem_req) begin
                nreq++;
                fl = mem_line;
                ff = mem_first;
                delivered = 0;
                busy = 1'b1;
                repeat (lat - 1) @(negedge clk);
                for (int b = 0; b < 4; b++) begin
                    repeat (b == 0 ? 1 : gap) @(negedge clk);
                    mem_valid = 1'b1;
                    mem_data  = pat({fl, 2'(int'(ff) + b)});
                    delivered = b + 1;
                    @(negedge clk);
                    mem_valid = 1'b0;
                end
                busy = 1'b0;
            end
        end
    end

    task automatic rd(input logic [9:0] a, input bit exp_miss);
        int n0, waited, pos, dl;
        bit busy0, bz, mv;
        logic [7:0] fl0;
        logic [31:0] got;
        n0 = nreq;
        @(negedge clk);
        cpu_req  = 1'b1;
        cpu_addr = a;
        #1;
        busy0 = busy;
        fl0 = fl;
        waited = 0;
        while (!cpu_rdy && waited < 400) begin
            @(negedge clk);
            #1;
            waited++;
        end
        got = cpu_rdata; mv = mem_valid; dl = delivered; bz = busy;
        cpu_req = 1'b0;
        chk(waited < 400, "R5", "request never served", 32'(waited), 32'd0);
        chk(got == pat(a), exp_miss ? "R4" : (busy0 ? "R5" : "R1"), "read data", got, pat(a));
        chk(nreq - n0 == int'(exp_miss), exp_miss ? "R2" : "R7", "memory request count",
            32'(nreq - n0), 32'(exp_miss));
        if (exp_miss) begin
            pos = (int'(a[1:0]) - int'(ff)) & 3;
            chk(ff == (cfg_wrap ? a[1:0] : 2'd0), "R3", "first word offset", 32'(ff),
                32'(cfg_wrap ? a[1:0] : 2'd0));
            chk(fl == a[9:2], "R2", "line address", 32'(fl), 32'(a[9:2]));
            chk(mv && dl == pos + 1, "R4", "restart beat", 32'(dl), 32'(pos + 1));
        end else if (busy0 && fl0 == a[9:2]) begin
            pos = (int'(a[1:0]) - int'(ff)) & 3;
            chk(dl > pos, "R5", "served before arrival", 32'(dl), 32'(pos + 1));
            if (waited > 0)
                chk(mv && dl == pos + 1, "R5", "stalled word release beat", 32'(dl), 32'(pos + 1));
        end else if (busy0) begin
            chk(!bz && waited > 0, "R6", "other line served during fill", 32'(bz), 32'd0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL watchdog: run hung (R1..R9 incomplete) actual=timeout expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R9: quiet outputs and empty cache after reset
        @(negedge clk); #1;
        chk(cpu_rdy == 1'b0, "R9", "cpu_rdy after reset", 32'(cpu_rdy), 32'd0);
        chk(mem_req == 1'b0, "R9", "mem_req after reset", 32'(mem_req), 32'd0);
        @(negedge clk);
        cpu_req = 1'b1; cpu_addr = mk(0, 0, 0);
        #1;
        chk(cpu_rdy == 1'b0, "R9", "hit on empty cache", 32'(cpu_rdy), 32'd0);
        cpu_req = 1'b0;

        // sweep: both orders, every set, every missed offset (R1..R5, R7)
        for (int m = 0; m < 2; m++) begin
            for (int s = 0; s < 4; s++) begin
                for (int o = 0; o < 4; o++) begin
                    cfg_wrap = (m == 0);
                    lat = 1 + (o % 2);
                    gap = (s + o) % 3;
                    rd(mk(1 + m * 4 + o, s, o), 1'b1);
                    for (int k = 1; k < 4; k++) rd(mk(1 + m * 4 + o, s, (o + k) % 4), 1'b0);
                    for (int k = 0; k < 4; k++) rd(mk(1 + m * 4 + o, s, k), 1'b0);
                end
            end
        end

        // R8: three lines through one set
        cfg_wrap = 1'b1; lat = 1; gap = 0;
        rd(mk(40, 1, 0), 1'b1);
        rd(mk(41, 1, 0), 1'b1);
        rd(mk(42, 1, 0), 1'b1);   // R8: evicts tag 40
        rd(mk(41, 1, 1), 1'b0);   // R8: newer line survives
        rd(mk(40, 1, 2), 1'b1);   // R8: evicted line misses, evicts 41
        rd(mk(42, 1, 3), 1'b0);
        rd(mk(41, 1, 0), 1'b1);

        // R6: resident line requested during another line's fill
        lat = 2; gap = 3;
        rd(mk(50, 2, 1), 1'b1);
        repeat (20) @(negedge clk);
        rd(mk(51, 3, 0), 1'b1);
        rd(mk(50, 2, 1), 1'b0);   // R6: must wait for refill
        rd(mk(50, 2, 3), 1'b0);

        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule